// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one external bus transfer per request for a processor with a 16-bit address, where the low address byte and the 8-bit data share one set of pins. The high address byte goes out on its own unidirectional bus. During the first clock of a transfer, the shared bus carries the low address byte and a latch strobe tells external logic to capture it. For the rest of the transfer, the shared bus carries data: the controller drives the write byte, or releases the bus so the device can return a read byte.

Each transfer has three states: T1 (address phase), T2 (strobe asserted, READY sampled) and T3 (read data captured, last strobe cycle). While READY is low, wait states are inserted between T2 and T3 so that slow devices can be served. For an I/O transfer, the 8-bit port number is copied onto both address halves. A hold request takes effect only between transfers. While hold is granted, both address buses are floated and the controller reports hold-acknowledge.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the controller is idle: ale, rd_stb, wr_stb, ad_oe, io_m, hlda and done are 0, a_oe is 1 and a_hi is 0.
- R2: When req is sampled high in idle with hold low, the next cycle is T1. In T1 ale=1, ad_oe=1, ad_out holds addr[7:0] and a_hi holds addr[15:8] for a memory transfer.
- R3: When io=1, a_hi holds addr[7:0] (the port number) as well as ad_out, and io_m=1 from T1 through T3. When io=0, io_m is 0.
- R4: On a read (wr=0), rd_stb is high from T2 through T3 and ad_oe is 0 in those cycles. rdata takes the value of ad_in sampled at the clock edge that ends T3.
- R5: On a write (wr=1), wr_stb is high from T2 through T3, with ad_oe=1 and ad_out equal to wdata in those cycles.
- R6: READY is sampled at the edge ending T2 and at the edge ending each wait state. Each low sample adds one wait state, so the strobe stays high for exactly 2 + (number of low samples) cycles.
- R7: done is high for exactly one cycle, the cycle after T3. rdata is valid in that cycle.
- R8: If hold is high in idle, hlda goes to 1 on the next cycle. While hlda=1, a_oe, ad_oe, rd_stb, wr_stb and ale are 0 and req is ignored. hlda returns to 0 the cycle after hold falls.
- R9: A hold raised during a transfer does not cut it short: the transfer completes with done, and hlda rises the cycle after done.
- R10: rd_stb and wr_stb are never high together, and neither is high while ale is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Transfer request, sampled in idle |
| addr | input | 16 | Transfer address (port number in bits 7:0 for I/O) |
| wdata | input | 8 | Write data |
| wr | input | 1 | 1 = write, 0 = read |
| io | input | 1 | 1 = I/O space, 0 = memory space |
| ready | input | 1 | Device ready; low inserts wait states |
| hold | input | 1 | Bus hold request |
| ad_in | input | 8 | Value on the shared address/data pins |
| a_hi | output | 8 | High address bus |
| a_oe | output | 1 | Output enable of the high address bus |
| ad_out | output | 8 | Value driven on the shared pins |
| ad_oe | output | 1 | Output enable of the shared pins |
| ale | output | 1 | Address latch strobe (T1) |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| io_m | output | 1 | 1 during an I/O transfer |
| hlda | output | 1 | Hold acknowledge |
| rdata | output | 8 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench mixes random reads and writes, in both spaces and with zero to three wait states, with directed hold scenarios. The strobe is checked in every cycle of each transfer and must be low in the done cycle. An off-by-one in READY sampling therefore shows up as a strobe that is too short or too long, and as done arriving in the wrong cycle. ad_in carries a decoy value until T3, so a design that captures read data early or late stores the wrong byte. Hold is raised mid-transfer to catch a design that aborts the transfer. req is held high during hold to catch a design that starts a transfer while the buses are floated. I/O transfers use differing address bytes, so a design that does not copy the port number shows the wrong high byte.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [2*DW-1:0] addr,
  input  logic [DW-1:0]   wdata,
  input  logic            wr,
  input  logic            io,
  input  logic            ready,
  input  logic            hold,
  input  logic [DW-1:0]   ad_in,
  output logic [DW-1:0]   a_hi,
  output logic            a_oe,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic            ale,
  output logic            rd_stb,
  output logic            wr_stb,
  output logic            io_m,
  output logic            hlda,
  output logic [DW-1:0]   rdata,
  output logic            done
);
  localparam int AW = 2 * DW;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_HOLD} st_t;
  st_t st;

  logic [DW-1:0] hi_q, lo_q, wd_q;
  logic          wr_q, io_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      hi_q  <= '0;
      lo_q  <= '0;
      wd_q  <= '0;
      wr_q  <= 1'b0;
      io_q  <= 1'b0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (hold) st <= S_HOLD;
          else if (req) begin
            lo_q <= addr[DW-1:0];
            hi_q <= io ? addr[DW-1:0] : addr[AW-1:DW];
            wd_q <= wdata;
            wr_q <= wr;
            io_q <= io;
            st   <= S_T1;
          end
        S_T1: st <= S_T2;
        S_T2, S_TW: st <= ready ? S_T3 : S_TW;
        S_T3: begin
          st   <= S_IDLE;
          done <= 1'b1;
          if (!wr_q) rdata <= ad_in;
        end
        S_HOLD: if (!hold) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic strobe, in_cyc;
  assign strobe = (st == S_T2) || (st == S_TW) || (st == S_T3);
  assign in_cyc = strobe || (st == S_T1);

  assign ale    = (st == S_T1);
  assign rd_stb = strobe && !wr_q;
  assign wr_stb = strobe && wr_q;
  assign a_hi   = hi_q;
  assign a_oe   = (st != S_HOLD);
  assign ad_out = (st == S_T1) ? lo_q : wd_q;
  assign ad_oe  = (st == S_T1) || (strobe && wr_q);
  assign io_m   = in_cyc && io_q;
  assign hlda   = (st == S_HOLD);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb) && !(ale && (rd_stb || wr_stb)));

  // R2
  ale_then_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (rd_stb || wr_stb) && !ale);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  wait_extends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && st != S_T3 && !ready) |=> (rd_stb || wr_stb));

  // R8
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !a_oe && !ad_oe && !rd_stb && !wr_stb && !ale);

  // R9
  no_hlda_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_cyc |-> !hlda);
endmodule

// File: tb/mux_bus_ctrl_tb.sv
module mux_bus_ctrl_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic req = 0, wr = 0, io = 0, ready = 1, hold = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0, ad_in = 0;
  logic [7:0] a_hi, ad_out, rdata;
  logic a_oe, ad_oe, ale, rd_stb, wr_stb, io_m, hlda, done;

  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  mux_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata), .wr(wr),
    .io(io), .ready(ready), .hold(hold), .ad_in(ad_in), .a_hi(a_hi), .a_oe(a_oe),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .io_m(io_m), .hlda(hlda), .rdata(rdata), .done(done)
  );

  function automatic logic [7:0] exp_hi(input logic [15:0] a, input logic i);
    return i ? a[7:0] : a[15:8];
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_op(input logic [15:0] a, input logic [7:0] d, input logic w,
                        input logic i, input int waits, input logic hold_mid);
    logic [7:0] rv;
    rv = 8'($urandom);
    @(negedge clk);
    req = 1; addr = a; wdata = d; wr = w; io = i; ad_in = ~rv;
    @(negedge clk);
    req = 0;
    chk(ale == 1, "R2 ale in T1", ale, 1);
    chk(done == 0, "R7 done low in T1", done, 0);
    chk(a_hi == exp_hi(a, i), "R2/R3 a_hi", a_hi, exp_hi(a, i));
    chk(ad_oe && ad_out == a[7:0], "R2 low addr on ad", ad_out, a[7:0]);
    chk(!rd_stb && !wr_stb, "R10 no strobe with ale", {rd_stb, wr_stb}, 0);
    chk(io_m == i, "R3 io_m in T1", io_m, i);
    if (hold_mid) hold = 1;
    for (int k = 0; k <= waits; k++) begin
      @(negedge clk);
      chk(rd_stb == !w && wr_stb == w, "R4/R5/R6 strobe active", {rd_stb, wr_stb}, {!w, w});
      chk(!(rd_stb && wr_stb) && !ale, "R10 exclusive", {ale, rd_stb, wr_stb}, 0);
      if (w) chk(ad_oe && ad_out == d, "R5 write data", ad_out, d);
      else   chk(!ad_oe, "R4 ad released", ad_oe, 0);
      chk(io_m == i, "R3 io_m", io_m, i);
      chk(done == 0, "R6 no early done", done, 0);
      ready = (k >= waits);
    end
    @(negedge clk);
    chk(rd_stb == !w && wr_stb == w, "R6 strobe in T3", {rd_stb, wr_stb}, {!w, w});
    chk(done == 0, "R7 done low in T3", done, 0);
    ad_in = rv;
    @(negedge clk);
    ad_in = ~rv;
    chk(done == 1, "R7 done pulse", done, 1);
    chk(!rd_stb && !wr_stb, "R6 strobe width", {rd_stb, wr_stb}, 0);
    chk(io_m == 0, "R3 io_m released", io_m, 0);
    if (!w) chk(rdata == rv, "R4 read data", rdata, rv);
    ready = 1;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_P * 3);
    @(negedge clk);
    chk(!ale && !rd_stb && !wr_stb && !ad_oe && !io_m && !hlda && !done && a_oe && a_hi == 0,
        "R1 reset state", {ale, rd_stb, wr_stb, ad_oe, io_m, hlda, done, a_oe}, 8'h01);
    rst_n = 1;

    run_op(16'h12AB, 8'h5C, 0, 0, 0, 0);
    run_op(16'h12AB, 8'h5C, 1, 0, 0, 0);
    run_op(16'h3477, 8'hE1, 0, 1, 2, 0);
    run_op(16'hFF00, 8'h3C, 1, 1, 3, 0);

    for (int n = 0; n < 200; n++)
      run_op(16'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 3)), 0);

    // R9: hold raised during a transfer
    run_op(16'hA5C3, 8'h99, 0, 0, 1, 1);
    @(negedge clk);
    chk(hlda == 1, "R9 hlda after done", hlda, 1);
    chk(!a_oe && !ad_oe, "R8 buses floated", {a_oe, ad_oe}, 0);
    // R8: requests ignored while held
    req = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(hlda && !ale && !rd_stb && !wr_stb, "R8 req ignored in hold", {hlda, ale, rd_stb, wr_stb}, 4'h8);
    end
    req = 0; hold = 0;
    @(negedge clk);
    chk(hlda == 0 && a_oe == 1, "R8 hold release", {hlda, a_oe}, 2'b01);

    // R8: hold from idle
    hold = 1;
    @(negedge clk);
    @(negedge clk);
    chk(hlda == 1 && a_oe == 0, "R8 hold from idle", {hlda, a_oe}, 2'b10);
    hold = 0;
    @(negedge clk);
    chk(hlda == 0, "R8 hlda drops", hlda, 0);
    run_op(16'h0F0F, 8'h42, 1, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule